// File: doc/BRIEF.md
# Double Bus Fault Halt Controller

This block watches how each bus cycle of a processor core ends and decides when the core has to stop for good. A bus cycle that ends in a bus error or an address error is a fault. The first such fault starts exception processing. If a second fault arrives while that processing is still under way, the block latches a halted state. In that state it drives an active-low halt line low and stalls the core. Only reset clears it.

A fault that arrives after the exception handler has reported completion is an ordinary fault and starts a new exception window. A cycle that ends in retry is not a fault. It only stalls the core for that cycle, so the same access can be repeated as often as the bus asks. Bus arbitration is never blocked by this block, and its grant-enable output stays high in every state, including halted.

Top module: `dbf_halt_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is idle with `halt_n`=1, `halted`=0 and `grant_en`=1. `core_stall` follows only the current retry input.
- R2: In idle, a valid termination coded 2'b01 (bus error) or 2'b10 (address error) opens the exception window. It does not halt.
- R3: In the exception window, a fault with `exc_active`=1 and `exc_done`=0 makes `halted`=1 and `halt_n`=0 from the following cycle.
- R4: Once halted, the block stays halted whatever the termination, `exc_active` and `exc_done` inputs do, until `rst_n` is sampled low.
- R5: `grant_en` is 1 in every state, including halted.
- R6: `exc_done` in the exception window, with no fault in the same cycle, returns the block to idle. A later fault then only opens a new window.
- R7: A valid termination coded 2'b11 (retry) never counts as a fault. It raises `core_stall` in the same cycle, and any number of retries in a row leave the state unchanged.
- R8: A fault and `exc_done` in the same cycle during the window are handled completion first. The fault opens a fresh window and does not halt.
- R9: A fault in the window while `exc_active`=0 does not halt. The window stays open.
- R10: Code 2'b00 (normal end), or any code with `term_valid`=0, has no effect on the state.
- R11: `core_stall` is 1 for as long as the block is halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| term_valid | input | 1 | A bus cycle ends this clock |
| term_code | input | 2 | How it ended: 00 normal, 01 bus error, 10 address error, 11 retry |
| exc_active | input | 1 | Core reports exception processing in progress |
| exc_done | input | 1 | Single-cycle strobe: exception processing finished |
| halt_n | output | 1 | Active-low halt line |
| core_stall | output | 1 | Stall request to the core |
| halted | output | 1 | High in the halted state |
| grant_en | output | 1 | Bus arbitration grant path enabled |

## Verification
The assertions take `exc_done` to be a one-cycle strobe. They also take the termination code to be meaningful only when `term_valid` is high, and `exc_active` to be the core's own view of the window, which may differ from this block's state. The stimulus draws every input independently each cycle, with weights that make faults, retries and completion strobes frequent enough to reach the halted state often. Occasional resets are inserted so that every state is entered many times. Directed sequences cover the same-cycle fault-and-completion case, a fault with `exc_active` low, and long runs of retries.

// File: rtl/dbf_pkg.sv
// Shared types for the double bus fault halt controller.
// Assumes a 2-bit termination code whose values are fixed by the bus side.
package dbf_pkg;
    localparam int TERM_W = 2;

    typedef enum logic [TERM_W-1:0] {
        TERM_OK    = 2'b00,
        TERM_BERR  = 2'b01,
        TERM_AERR  = 2'b10,
        TERM_RETRY = 2'b11
    } term_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_EXC  = 2'b01,
        ST_HALT = 2'b10
    } dbf_state_e;
endpackage

// File: rtl/dbf_term_decode.sv
// Classifies one bus termination into a fault pulse or a retry pulse.
// Assumes term_code is only meaningful while term_valid is high.
module dbf_term_decode
    import dbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              term_valid,
    input  logic [TERM_W-1:0] term_code,
    output logic              fault,
    output logic              retry
);
    // Decode termination into fault / retry flags.
    always_comb begin
        fault = 1'b0;
        retry = 1'b0;
        if (term_valid) begin
            case (term_e'(term_code))
                TERM_BERR,
                TERM_AERR:  fault = 1'b1;
                TERM_RETRY: retry = 1'b1;
                default:    ;
            endcase
        end
    end

    // R7
    // retry_not_fault_chk
    retry_not_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term_valid && term_code == TERM_RETRY) |-> !fault);
endmodule

// File: rtl/dbf_fault_fsm.sv
// Tracks the exception window and latches the halted state on a double fault.
// Assumes exc_done is a one-cycle strobe; completion wins over a fault in the same cycle.
module dbf_fault_fsm
    import dbf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    input  logic exc_active,
    input  logic exc_done,
    output logic halted
);
    dbf_state_e st_q, st_d;

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (fault) st_d = ST_EXC;
            ST_EXC: begin
                if (exc_done)                st_d = fault ? ST_EXC : ST_IDLE;
                else if (fault && exc_active) st_d = ST_HALT;
            end
            ST_HALT: st_d = ST_HALT;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign halted = (st_q == ST_HALT);

    // R3
    // double_fault_halt_chk
    double_fault_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXC && fault && exc_active && !exc_done) |=> halted);

    // R4
    // halt_sticky_chk
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R6
    // done_returns_idle_chk
    done_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXC && exc_done && !fault) |=> (st_q == ST_IDLE));

    // R9
    // inactive_no_halt_chk
    inactive_no_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXC && fault && !exc_active && !exc_done) |=> !halted);

    // R8
    // done_first_chk
    done_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXC && fault && exc_done) |=> (st_q == ST_EXC));
endmodule

// File: rtl/dbf_halt_ctrl.sv
// Top of the double bus fault halt controller.
// Assumes synchronous active-low reset; arbitration is never gated here.
module dbf_halt_ctrl
    import dbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              term_valid,
    input  logic [TERM_W-1:0] term_code,
    input  logic              exc_active,
    input  logic              exc_done,
    output logic              halt_n,
    output logic              core_stall,
    output logic              halted,
    output logic              grant_en
);
    logic fault, retry, halted_s;

    dbf_term_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .term_valid (term_valid),
        .term_code  (term_code),
        .fault      (fault),
        .retry      (retry)
    );

    dbf_fault_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault      (fault),
        .exc_active (exc_active),
        .exc_done   (exc_done),
        .halted     (halted_s)
    );

    // Drive the outputs from the latched state and the current retry.
    always_comb begin
        halted     = halted_s;
        halt_n     = ~halted_s;
        core_stall = halted_s | retry;
        grant_en   = 1'b1;
    end

    // R11
    // stall_when_halted_chk
    stall_when_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> core_stall);

    // R3
    // halt_line_low_chk
    halt_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !halt_n);
endmodule

// File: tb/dbf_halt_ctrl_tb.sv
`timescale 1ns/1ps
module dbf_halt_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       term_valid = 1'b0;
    logic [1:0] term_code = 2'b00;
    logic       exc_active = 1'b0;
    logic       exc_done = 1'b0;
    logic       halt_n, core_stall, halted, grant_en;

    int errors = 0;
    int checks = 0;
    int ref_st = 0; // 0 idle, 1 exception window, 2 halted
    bit finished = 0;

    always #2.5 clk = ~clk;

    dbf_halt_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .term_valid(term_valid), .term_code(term_code),
        .exc_active(exc_active), .exc_done(exc_done), .halt_n(halt_n),
        .core_stall(core_stall), .halted(halted), .grant_en(grant_en)
    );

    function automatic int ref_next(int st, bit rn, bit v, bit [1:0] c, bit a, bit d);
        bit f = v && (c == 2'b01 || c == 2'b10);
        if (!rn) return 0;
        case (st)
            0: return f ? 1 : 0;
            1: begin
                if (d)      return f ? 1 : 0;
                if (f && a) return 2;
                return 1;
            end
            default: return 2;
        endcase
    endfunction

    task automatic chk(string tag, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        bit eh = (ref_st == 2);
        bit es = eh || (term_valid && term_code == 2'b11);
        chk({tag, " halted (R3 R4)"}, halted, eh);
        chk({tag, " halt_n (R3)"}, halt_n, !eh);
        chk({tag, " core_stall (R7 R11)"}, core_stall, es);
        chk({tag, " grant_en (R5)"}, grant_en, 1'b1);
    endtask

    task automatic step(string tag, bit rn, bit v, bit [1:0] c, bit a, bit d);
        rst_n = rn; term_valid = v; term_code = c; exc_active = a; exc_done = d;
        #1;
        check_all(tag);
        @(posedge clk);
        ref_st = ref_next(ref_st, rn, v, c, a, d);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        step("R1 reset", 0, 0, 2'b00, 0, 0);
        step("R1 reset", 0, 1, 2'b11, 1, 1);
        step("R1 after reset", 1, 0, 2'b00, 0, 0);
        // R10 normal and invalid codes do nothing
        step("R10 normal", 1, 1, 2'b00, 1, 0);
        step("R10 invalid", 1, 0, 2'b01, 1, 0);
        step("R10 check", 1, 0, 2'b00, 0, 0);
        // R2 first fault, then R3 double fault
        step("R2 first fault", 1, 1, 2'b01, 0, 0);
        step("R2 window", 1, 0, 2'b00, 1, 0);
        // R7 long retry run inside the window
        for (int i = 0; i < 40; i++) step("R7 retry", 1, 1, 2'b11, 1, 0);
        step("R3 second fault", 1, 1, 2'b10, 1, 0);
        step("R3 halted", 1, 0, 2'b00, 0, 0);
        // R4 halted ignores everything but reset
        for (int i = 0; i < 20; i++)
            step("R4 sticky", 1, 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
        step("R4 reset release", 0, 0, 2'b00, 0, 0);
        step("R1 idle", 1, 0, 2'b00, 0, 0);
        // R6 completion returns to idle; later fault is ordinary
        step("R6 fault", 1, 1, 2'b01, 0, 0);
        step("R6 done", 1, 0, 2'b00, 1, 1);
        step("R6 new fault", 1, 1, 2'b10, 1, 0);
        step("R6 no halt", 1, 0, 2'b00, 1, 0);
        // R8 fault with completion in same cycle
        step("R8 fault+done", 1, 1, 2'b01, 1, 1);
        step("R8 no halt", 1, 0, 2'b00, 1, 0);
        // R9 fault in window with exc_active low
        step("R9 inactive fault", 1, 1, 2'b01, 0, 0);
        step("R9 no halt", 1, 0, 2'b00, 1, 0);
        step("R9 then double", 1, 1, 2'b10, 1, 0);
        step("R11 halted stall", 1, 0, 2'b00, 0, 0);
        // Constrained random
        for (int i = 0; i < 4000; i++) begin
            bit rn = ($urandom_range(0, 99) > 1);
            bit v  = ($urandom_range(0, 99) < 60);
            bit [1:0] c = 2'($urandom);
            bit a  = ($urandom_range(0, 99) < 75);
            bit d  = ($urandom_range(0, 99) < 15);
            step("R2 R3 R6 R8 random", rn, v, c, a, d);
        end
        finish_run();
    end
endmodule